// File: doc/BRIEF.md
# Synchronous Burst Memory Cycle Controller

This block sits in front of a flow-through synchronous burst memory. On every rising clock edge it samples the chip enables, the two address strobes, the advance input and the write controls. From them it classifies the cycle as a deselect, a new read, a new write, a continued read or write, or a suspended read or write. It also says where the address comes from: nowhere, the external bus, the next burst position or the current one. A two-bit burst counter produces the address used in the cycle, in either linear or interleaved order.

The word is 36 bits wide and split into four lanes. Each lane holds eight data bits and one parity bit. The controller turns global write, byte-write enable and the four per-lane write inputs into a lane mask and a per-bit write enable. It drives the data bus only during read cycles while the asynchronous output enable is low.

The classification, the address and the mask are registered once and then used in the cycle that follows the sampling edge. Read data therefore flows out with no further pipeline stage. The storage array is not part of the block.

Top module: `sbc_cycle_ctrl`

## Requirements
- R1: The device counts as selected only when `ce_a_n` is 0, `ce_b_n` is 0 and `ce_c` is 1. Any other combination is not selected.
- R2: When `strobe_proc_n` is 0 and `ce_a_n` is 0, the result depends on selection. If selected, the cycle is a new read (op_class 1) at the external address (addr_sel 1), whatever the write inputs are. If not selected, it is a deselect (op_class 0, addr_sel 0).
- R3: When `ce_a_n` is 1, `strobe_proc_n` has no effect. The cycle is decoded exactly as if `strobe_proc_n` were 1.
- R4: When the processor strobe is inactive and `strobe_ctl_n` is 0, the result depends on selection. If selected, the cycle is a new write (op_class 2) when the write qualifier is set, otherwise a new read (op_class 1), both with addr_sel 1. If not selected, it is a deselect (op_class 0, addr_sel 0).
- R5: When both strobes are inactive and a burst is open, the chip enables are ignored. With `adv_n` = 0 the cycle continues: op_class 4 for a write or 3 for a read, with addr_sel 2 (next). With `adv_n` = 1 the cycle is suspended: op_class 6 for a write or 5 for a read, with addr_sel 3 (current). The write qualifier chooses between read and write.
- R6: A burst is open after any non-deselect cycle. When both strobes are inactive and no burst is open (after reset or after a deselect), the cycle is again a deselect.
- R7: The write qualifier is set when `gwr_n` is 0, or when `bwe_n` is 0 and at least one bit of `lane_wr_n` is 0.
- R8: On write cycles, `lane_mask` is all ones when `gwr_n` is 0. Otherwise bit n of `lane_mask` is set when `bwe_n` is 0 and `lane_wr_n[n]` is 0. On read and deselect cycles the mask is zero. Bit n of `lane_mask` drives `bit_wr_en` bits 8n to 8n+7 and parity bit 32+n.
- R9: A new cycle loads `addr_ext` into `burst_addr`, with the burst count reset to 0. Each continue adds one to the two-bit count, wrapping. The two low address bits are start plus count modulo 4 when `burst_order` = 0 (linear), and start XOR count when `burst_order` = 1 (interleaved). The upper bits stay at the start value. Suspend and deselect keep `burst_addr`.
- R10: `bus_drive` is 1 only while the registered op_class is 1, 3 or 5 and `oe_n` is 0. It follows `oe_n` with no clock edge in between.
- R11: op_class, addr_sel, burst_addr and lane_mask reflect the inputs sampled at the most recent rising edge, through exactly one register stage.
- R12: While `rst_n` is 0, and after it, until the first sampling edge, the outputs are as follows. op_class and addr_sel are 0, lane_mask and bit_wr_en are 0, burst_addr is 0, bus_drive is 0, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| ce_a_n | input | 1 | Active-low enable, also gates the processor strobe |
| ce_b_n | input | 1 | Active-low enable for depth expansion |
| ce_c | input | 1 | Active-high enable for depth expansion |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved |
| addr_ext | input | AW | External address |
| op_class | output | 3 | Registered cycle class, 0 to 6 |
| addr_sel | output | 2 | Address source: 0 none, 1 external, 2 next, 3 current |
| burst_addr | output | AW | Address used in the current cycle |
| lane_mask | output | LANES | Lanes written in the current cycle |
| bit_wr_en | output | LANES*9 | Per-bit write enable |
| bus_drive | output | 1 | Data bus output enable |

## Verification
A wrong decode shows up as a wrong op_class or addr_sel in the cycle right after the sampling edge. A wrong open-burst flag is different: it stays hidden until a cycle with both strobes inactive, which then continues when it should deselect, or the other way round. A counter or base register that goes astray shows up only on the next continue, where burst_addr leaves the expected order. An error in the lane mask is seen at the same edge as the write, in both lane_mask and bit_wr_en. The bench compares every output on every cycle against a behavioural model, so each of these faults is reported within one cycle of becoming visible.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

    typedef enum logic [2:0] {
        OP_DESEL   = 3'd0,
        OP_RD_NEW  = 3'd1,
        OP_WR_NEW  = 3'd2,
        OP_RD_CONT = 3'd3,
        OP_WR_CONT = 3'd4,
        OP_RD_SUSP = 3'd5,
        OP_WR_SUSP = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EXT  = 2'd1,
        SEL_NEXT = 2'd2,
        SEL_CUR  = 2'd3
    } asel_e;

    function automatic logic op_is_write(input op_e op);
        return (op == OP_WR_NEW) || (op == OP_WR_CONT) || (op == OP_WR_SUSP);
    endfunction

    function automatic logic op_is_read(input op_e op);
        return (op == OP_RD_NEW) || (op == OP_RD_CONT) || (op == OP_RD_SUSP);
    endfunction

endpackage

// File: rtl/sbc_cycle_decode.sv
`timescale 1ns/1ps
module sbc_cycle_decode
    import sbc_pkg::*;
(
    input  logic  ce_a_n,
    input  logic  ce_b_n,
    input  logic  ce_c,
    input  logic  strobe_proc_n,
    input  logic  strobe_ctl_n,
    input  logic  adv_n,
    input  logic  wr_qual,
    input  logic  burst_open,
    output op_e   op,
    output asel_e asel
);
    logic selected;
    logic proc_hit;

    // Selection needs all three enables in their active state.
    assign selected = ~ce_a_n & ~ce_b_n & ce_c;
    // The processor strobe only counts while the first enable is active.
    assign proc_hit = ~strobe_proc_n & ~ce_a_n;

    always_comb begin
        op   = OP_DESEL;
        asel = SEL_NONE;
        if (proc_hit) begin
            if (selected) begin
                op   = OP_RD_NEW;
                asel = SEL_EXT;
            end
        end else if (!strobe_ctl_n) begin
            if (selected) begin
                op   = wr_qual ? OP_WR_NEW : OP_RD_NEW;
                asel = SEL_EXT;
            end
        end else if (burst_open) begin
            if (!adv_n) begin
                op   = wr_qual ? OP_WR_CONT : OP_RD_CONT;
                asel = SEL_NEXT;
            end else begin
                op   = wr_qual ? OP_WR_SUSP : OP_RD_SUSP;
                asel = SEL_CUR;
            end
        end
    end
endmodule

// File: rtl/sbc_write_lanes.sv
`timescale 1ns/1ps
module sbc_write_lanes #(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             wr_qual,
    output logic [LANES-1:0] lane_en
);
    logic any_lane;

    assign any_lane = ~&lane_wr_n;
    assign wr_qual  = ~gwr_n | (~bwe_n & any_lane);

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign lane_en[n] = ~gwr_n | (~bwe_n & ~lane_wr_n[n]);
    end
endmodule

// File: rtl/sbc_burst_step.sv
`timescale 1ns/1ps
module sbc_burst_step
    import sbc_pkg::*;
#(
    parameter int AW = 17,
    parameter int CW = 2
) (
    input  asel_e         asel,
    input  logic          order,
    input  logic [AW-1:0] addr_ext,
    input  logic [AW-1:0] base_q,
    input  logic [CW-1:0] cnt_q,
    input  logic [AW-1:0] addr_q,
    output logic [AW-1:0] base_d,
    output logic [CW-1:0] cnt_d,
    output logic [AW-1:0] addr_d
);
    logic [CW-1:0] low;

    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        case (asel)
            SEL_EXT:  begin base_d = addr_ext; cnt_d = '0; end
            SEL_NEXT: cnt_d = cnt_q + 1'b1;
            default:  ;
        endcase
        low = order ? (base_d[CW-1:0] ^ cnt_d) : (base_d[CW-1:0] + cnt_d);
        if (asel == SEL_NONE || asel == SEL_CUR) begin
            addr_d = addr_q;
        end else begin
            addr_d = {base_d[AW-1:CW], low};
        end
    end
endmodule

// File: rtl/sbc_cycle_ctrl.sv
`timescale 1ns/1ps
module sbc_cycle_ctrl
    import sbc_pkg::*;
#(
    parameter int AW        = 17,
    parameter int LANES     = 4,
    parameter int LANE_DATA = 8,
    localparam int CW       = 2,
    localparam int WORD_W   = LANES * (LANE_DATA + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_a_n,
    input  logic              ce_b_n,
    input  logic              ce_c,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              oe_n,
    input  logic              burst_order,
    input  logic [AW-1:0]     addr_ext,
    output logic [2:0]        op_class,
    output logic [1:0]        addr_sel,
    output logic [AW-1:0]     burst_addr,
    output logic [LANES-1:0]  lane_mask,
    output logic [WORD_W-1:0] bit_wr_en,
    output logic              bus_drive
);
    typedef struct packed {
        op_e              op;
        asel_e            asel;
        logic [LANES-1:0] lanes;
        logic             open;
        logic [AW-1:0]    base;
        logic [CW-1:0]    cnt;
        logic [AW-1:0]    addr;
    } state_t;

    state_t st_d, st_q;

    logic             wr_qual;
    logic [LANES-1:0] lane_en;
    op_e              dec_op;
    asel_e            dec_asel;
    logic [AW-1:0]    base_n;
    logic [CW-1:0]    cnt_n;
    logic [AW-1:0]    addr_n;

    sbc_write_lanes #(.LANES(LANES)) u_lanes (
        .gwr_n     (gwr_n),
        .bwe_n     (bwe_n),
        .lane_wr_n (lane_wr_n),
        .wr_qual   (wr_qual),
        .lane_en   (lane_en)
    );

    sbc_cycle_decode u_dec (
        .ce_a_n        (ce_a_n),
        .ce_b_n        (ce_b_n),
        .ce_c          (ce_c),
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctl_n  (strobe_ctl_n),
        .adv_n         (adv_n),
        .wr_qual       (wr_qual),
        .burst_open    (st_q.open),
        .op            (dec_op),
        .asel          (dec_asel)
    );

    sbc_burst_step #(.AW(AW), .CW(CW)) u_step (
        .asel     (dec_asel),
        .order    (burst_order),
        .addr_ext (addr_ext),
        .base_q   (st_q.base),
        .cnt_q    (st_q.cnt),
        .addr_q   (st_q.addr),
        .base_d   (base_n),
        .cnt_d    (cnt_n),
        .addr_d   (addr_n)
    );

    always_comb begin
        st_d       = st_q;
        st_d.op    = dec_op;
        st_d.asel  = dec_asel;
        st_d.lanes = op_is_write(dec_op) ? lane_en : '0;
        st_d.open  = (dec_op != OP_DESEL);
        st_d.base  = base_n;
        st_d.cnt   = cnt_n;
        st_d.addr  = addr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_DESEL, asel: SEL_NONE, lanes: '0, open: 1'b0,
                      base: '0, cnt: '0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign op_class   = st_q.op;
    assign addr_sel   = st_q.asel;
    assign burst_addr = st_q.addr;
    assign lane_mask  = st_q.lanes;
    assign bus_drive  = op_is_read(st_q.op) & ~oe_n;

    // Data bits of each lane sit low; the parity bits follow all data bits.
    for (genvar n = 0; n < LANES; n++) begin : g_bits
        assign bit_wr_en[n*LANE_DATA +: LANE_DATA]   = {LANE_DATA{st_q.lanes[n]}};
        assign bit_wr_en[LANES*LANE_DATA + n]        = st_q.lanes[n];
    end
endmodule

// File: rtl/sbc_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module sbc_cycle_ctrl_chk #(
    parameter int AW    = 17,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_a_n,
    input logic             ce_b_n,
    input logic             ce_c,
    input logic             strobe_proc_n,
    input logic             strobe_ctl_n,
    input logic             gwr_n,
    input logic             oe_n,
    input logic [2:0]       op_class,
    input logic [1:0]       addr_sel,
    input logic [AW-1:0]    burst_addr,
    input logic [LANES-1:0] lane_mask,
    input logic             bus_drive
);
    logic sel_in;
    logic rd_now;
    logic wr_now;
    assign sel_in = !ce_a_n && !ce_b_n && ce_c;
    assign rd_now = (op_class == 3'd1) || (op_class == 3'd3) || (op_class == 3'd5);
    assign wr_now = (op_class == 3'd2) || (op_class == 3'd4) || (op_class == 3'd6);

    p_proc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && sel_in) |=> (op_class == 3'd1 && addr_sel == 2'd1));

    p_proc_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && !ce_a_n && !sel_in) |=> (op_class == 3'd0 && addr_sel == 2'd0));

    p_ctl_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc_n && !strobe_ctl_n && !sel_in) |=> (op_class == 3'd0));

    p_global_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc_n && !strobe_ctl_n && sel_in && !gwr_n) |=> (lane_mask == {LANES{1'b1}}));

    p_write_has_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |-> (lane_mask != '0));

    p_read_no_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_now |-> (lane_mask == '0));

    p_drive_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (rd_now && !oe_n));

    p_suspend_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd5 || op_class == 3'd6) |-> $stable(burst_addr));
endmodule

bind sbc_cycle_ctrl sbc_cycle_ctrl_chk #(.AW(AW), .LANES(LANES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ce_a_n        (ce_a_n),
    .ce_b_n        (ce_b_n),
    .ce_c          (ce_c),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctl_n  (strobe_ctl_n),
    .gwr_n         (gwr_n),
    .oe_n          (oe_n),
    .op_class      (op_class),
    .addr_sel      (addr_sel),
    .burst_addr    (burst_addr),
    .lane_mask     (lane_mask),
    .bus_drive     (bus_drive)
);

// File: tb/sbc_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sbc_cycle_ctrl_tb_top;
    localparam int AW = 8;
    localparam int LN = 4;
    localparam int WW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_a_n = 1'b1, ce_b_n = 1'b1, ce_c = 1'b0;
    logic strobe_proc_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
    logic gwr_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1, burst_order = 1'b0;
    logic [LN-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr_ext = '0;
    logic [2:0]    op_class;
    logic [1:0]    addr_sel;
    logic [AW-1:0] burst_addr;
    logic [LN-1:0] lane_mask;
    logic [WW-1:0] bit_wr_en;
    logic          bus_drive;

    int total = 0;
    int bad = 0;

    // reference model state
    int m_op = 0, m_sel = 0, m_mask = 0, m_addr = 0, m_base = 0, m_cnt = 0;
    bit m_open = 0;
    string m_tag = "R12";

    always #5 clk = ~clk;

    sbc_cycle_ctrl #(.AW(AW), .LANES(LN), .LANE_DATA(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c),
        .strobe_proc_n(strobe_proc_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
        .burst_order(burst_order), .addr_ext(addr_ext), .op_class(op_class),
        .addr_sel(addr_sel), .burst_addr(burst_addr), .lane_mask(lane_mask),
        .bit_wr_en(bit_wr_en), .bus_drive(bus_drive)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model of one sampling edge, written from the requirements.
    task automatic model_edge();
        bit sel, wq, proc;
        int lo;
        sel  = !ce_a_n && !ce_b_n && ce_c;                                  // R1
        wq   = !gwr_n || (!bwe_n && lane_wr_n != 4'hF);                       // R7
        proc = !strobe_proc_n && !ce_a_n;
        m_op = 0; m_sel = 0;
        if (proc) begin
            m_tag = "R1 R2";
            if (sel) begin m_op = 1; m_sel = 1; end
        end else if (!strobe_ctl_n) begin
            m_tag = (!strobe_proc_n) ? "R3 R4 R7" : "R1 R4 R7";
            if (sel) begin m_op = wq ? 2 : 1; m_sel = 1; end
        end else if (m_open) begin
            m_tag = (!strobe_proc_n) ? "R3 R5 R7" : "R5 R7";
            if (!adv_n) begin m_op = wq ? 4 : 3; m_sel = 2; end
            else begin m_op = wq ? 6 : 5; m_sel = 3; end
        end else begin
            m_tag = "R6";
        end
        m_open = (m_op != 0);
        m_mask = 0;
        if (m_op == 2 || m_op == 4 || m_op == 6) begin
            for (int n = 0; n < LN; n++)
                if (!gwr_n || (!bwe_n && !lane_wr_n[n])) m_mask |= (1 << n);
        end
        if (m_sel == 1) begin m_base = addr_ext; m_cnt = 0; end
        if (m_sel == 2) m_cnt = (m_cnt + 1) % 4;
        if (m_sel == 1 || m_sel == 2) begin
            lo = burst_order ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
            m_addr = (m_base / 4) * 4 + lo;
        end
    endtask

    task automatic compare_all();
        longint exp_bits;
        bit exp_drv;
        exp_bits = 0;
        for (int n = 0; n < LN; n++)
            if (m_mask[n]) exp_bits |= (64'hFF << (8 * n)) | (64'h1 << (32 + n));
        exp_drv = (m_op == 1 || m_op == 3 || m_op == 5) && !oe_n;
        chk(op_class == m_op[2:0], {m_tag, " R11 op_class"}, op_class, m_op);
        chk(addr_sel == m_sel[1:0], {m_tag, " R11 addr_sel"}, addr_sel, m_sel);
        chk(lane_mask == m_mask[LN-1:0], "R8 lane_mask", lane_mask, m_mask);
        chk(bit_wr_en == exp_bits[WW-1:0], "R8 bit_wr_en", bit_wr_en, exp_bits);
        chk(burst_addr == m_addr[AW-1:0], "R9 burst_addr", burst_addr, m_addr);
        chk(bus_drive == exp_drv, "R10 bus_drive", bus_drive, exp_drv);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle_in();
        strobe_proc_n = 1; strobe_ctl_n = 1; adv_n = 1;
        gwr_n = 1; bwe_n = 1; lane_wr_n = '1;
    endtask

    task automatic select_on();
        ce_a_n = 0; ce_b_n = 0; ce_c = 1;
    endtask

    initial begin
        #100000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values, including with read inputs present
        oe_n = 0;
        #1;
        compare_all();
        rst_n = 1;
        @(negedge clk);
        #1;
        compare_all();                         // R12 after release, idle stays deselected

        // R6: both strobes inactive, nothing open -> deselect
        select_on(); idle_in(); adv_n = 0;
        step();

        // R2: processor strobe read ignores asserted writes
        strobe_proc_n = 0; gwr_n = 0; bwe_n = 0; lane_wr_n = 4'h0; addr_ext = 8'h21;
        step();
        // write follows as a wait cycle with qualifier (R5 suspend write)
        idle_in(); bwe_n = 0; lane_wr_n = 4'b1010;
        step();
        // R5 continue write, linear order
        adv_n = 0; lane_wr_n = 4'b0111;
        step();

        // R3: processor strobe with ce_a_n high is ignored, controller strobe starts write
        idle_in(); ce_a_n = 1; strobe_proc_n = 0; strobe_ctl_n = 0; gwr_n = 0; addr_ext = 8'h43;
        step();                                // not selected -> deselect (R4)
        select_on(); ce_a_n = 0; strobe_proc_n = 1;
        step();                                // R4 new write, all lanes (R8)

        // R9 linear wrap from start 3
        idle_in(); burst_order = 0; adv_n = 0;
        repeat (4) step();
        // R9 interleaved from start 2
        strobe_ctl_n = 0; addr_ext = 8'h96; adv_n = 1; burst_order = 1;
        step();
        idle_in(); adv_n = 0;
        repeat (3) step();
        // R5 suspend read holds address, enables ignored
        adv_n = 1; ce_c = 0;
        step();
        // R10 asynchronous output enable
        oe_n = 1; #1;
        chk(bus_drive == 1'b0, "R10 oe_n high releases bus", bus_drive, 0);
        oe_n = 0; #1;
        chk(bus_drive == 1'b1, "R10 oe_n low drives bus on read", bus_drive, 1);

        // R1: each enable alone can deselect with the controller strobe
        select_on(); ce_b_n = 1; strobe_ctl_n = 0;
        step();
        idle_in(); adv_n = 0;
        step();                                // R6 after deselect
        // R7: byte-write enable high makes lane writes a read
        select_on(); strobe_ctl_n = 0; bwe_n = 1; lane_wr_n = 4'h0; addr_ext = 8'h10;
        step();

        // randomized traffic
        for (int i = 0; i < 4000; i++) begin
            ce_a_n        = ($urandom % 8) == 0;
            ce_b_n        = ($urandom % 8) == 0;
            ce_c          = ($urandom % 8) != 0;
            strobe_proc_n = ($urandom % 7) != 0;
            strobe_ctl_n  = ($urandom % 4) != 0;
            adv_n         = ($urandom % 3) == 0;
            gwr_n         = ($urandom % 6) != 0;
            bwe_n         = ($urandom % 2) != 0;
            lane_wr_n     = 4'($urandom);
            oe_n          = ($urandom % 5) == 0;
            burst_order   = ($urandom % 2) != 0;
            addr_ext      = 8'($urandom);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule